// File: doc/BRIEF.md
# Prioritized Error Address Capture Register

This block sits beside a flash memory controller and records the double-word address tied to a fault. Four classes of fault arrive as one-cycle strobes, each with its own address. From most to least urgent they are an uncorrectable ECC error, a read-while-write conflict, a failed program/erase operation, and a corrected single-bit ECC error. Each class has a sticky flag and a private slot. The slot records the address of the first event of that class after the flag was last cleared.

The read port shows the slot of the most urgent class whose flag is active. Software clears a flag by writing one to its clear bit, and that also lets the slot take a new first address. The program/erase class is reported as an "operation good" status, which reads low while a failure is pending.

The two ECC classes report per-lane hits across the double words of one page. When more than one lane hits in the same cycle, the lowest lane is recorded, so address bit 3 reads 0 when both double words of a page fail together.

Top module: `flash_err_addr_cap`

## Requirements
- R1: The read address comes from the highest-priority active class. The ranking is ECC double error, then read-while-write, then program/erase failure, then single-bit correction.
- R2: While a class flag stays set, further events of that class do not change that class's recorded address.
- R3: Lower-priority events never change the read address while a higher-priority flag is set, across any sequence of three or more events. For example: two double errors, then a correction, must still show the first double-error address.
- R4: The read address is a byte address of ADDR_W bits whose three least significant bits are always 0.
- R5: When both ECC lanes of one page hit in the same cycle, the recorded address bit 3 is 0. A hit on lane 1 alone records bit 3 as 1. The page address supplies bits ADDR_W-1 down to 4.
- R6: `pe_good_o` is 1 after reset, goes to 0 the cycle after a program/erase failure strobe, and returns to 1 when that class is cleared.
- R7: A one on `flag_clr_i` clears the matching flag on the next edge and re-arms its slot. The bit order is bit 0 double error, bit 1 read-while-write, bit 2 program/erase, bit 3 correction.
- R8: An event arriving in the same cycle as the clear of its own class is recorded as a new first event, and the flag stays set.
- R9: A single-bit correction event sets its flag and records its address only while `sec_report_en_i` is 1.
- R10: Reset clears all flags and the read address to 0. When no flag is active, the read address holds the last address selected while a flag was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ded_lane_i | input | LANES | Per-lane uncorrectable ECC error strobes |
| ded_page_i | input | ADDR_W-4 | Page address of the ECC double error |
| rww_evt_i | input | 1 | Read-while-write error strobe |
| rww_dw_i | input | ADDR_W-3 | Double-word address of the read-while-write error |
| pe_fail_i | input | 1 | Program/erase failure strobe |
| pe_dw_i | input | ADDR_W-3 | Double-word address of the program/erase failure |
| sec_lane_i | input | LANES | Per-lane single-bit correction strobes |
| sec_page_i | input | ADDR_W-4 | Page address of the correction |
| sec_report_en_i | input | 1 | Enables recording of correction events |
| flag_clr_i | input | 4 | Write-one-to-clear strobes, one per class |
| ded_flag_o | output | 1 | Sticky double-error flag |
| rww_flag_o | output | 1 | Sticky read-while-write flag |
| pe_good_o | output | 1 | Operation good; low while a program/erase failure is pending |
| sec_flag_o | output | 1 | Sticky correction flag |
| err_addr_o | output | ADDR_W | Recorded byte address |

## Verification
Several properties are checked on every cycle by the assertions:
- slot stability while a flag is held (R2);
- clear and same-cycle re-capture (R7, R8);
- correction suppression while reporting is disabled (R9);
- alignment of the read address (R4);
- selection of the double-error slot whenever its flag is up (R1).

Only the bench scenarios can show some behaviours. These are the full priority cascade as flags are cleared one by one, the long three-event sequences (R3), lane-merge values on real page addresses (R5), and the hold of the last selected address after every flag has dropped (R10).

// File: rtl/flash_eac_pkg.sv
package flash_eac_pkg;
  localparam int NUM_CLS = 4;
  typedef enum logic [1:0] {
    CLS_DED = 2'd0,
    CLS_RWW = 2'd1,
    CLS_PEF = 2'd2,
    CLS_SEC = 2'd3
  } cls_e;
  localparam int DW_OFS = 3;
endpackage

// File: rtl/eac_lane_merge.sv
module eac_lane_merge #(
  parameter int PAGE_W = 19,
  parameter int LANES  = 2,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int OUT_W  = PAGE_W + LANE_W
) (
  input  logic [LANES-1:0]  lane_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              hit_o,
  output logic [OUT_W-1:0]  dw_o
);
  logic [LANE_W-1:0] low_idx;

  // lowest hitting lane wins, so simultaneous hits give index 0
  always_comb begin
    low_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (lane_i[i]) low_idx = LANE_W'(i);
    end
  end

  assign hit_o = |lane_i;
  assign dw_o  = {page_i, low_idx};
endmodule

// File: rtl/eac_slot.sv
module eac_slot #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit_i,
  input  logic [W-1:0] addr_i,
  input  logic         clr_i,
  output logic         flag_o,
  output logic [W-1:0] addr_o
);
  logic         flag_q, flag_d;
  logic [W-1:0] addr_q, addr_d;
  logic         load_en;

  assign load_en = hit_i && (clr_i || !flag_q);

  always_comb begin
    flag_d = flag_q;
    if (clr_i)      flag_d = hit_i;
    else if (hit_i) flag_d = 1'b1;
  end

  always_comb begin
    addr_d = addr_q;
    if (load_en) addr_d = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
    end else begin
      flag_q <= flag_d;
      addr_q <= addr_d;
    end
  end

  assign flag_o = flag_q;
  assign addr_o = addr_q;

  p_first_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> ($stable(addr_q) && flag_q));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit_i) |=> !flag_q);
  p_recapture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && hit_i) |=> (flag_q && addr_q == $past(addr_i)));
endmodule

// File: rtl/eac_read_sel.sv
module eac_read_sel #(
  parameter int W = 20,
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      act_i,
  input  logic [N-1:0][W-1:0] slot_i,
  output logic [W-1:0]      addr_o
);
  logic [W-1:0] sel;
  logic         any_act;
  logic [W-1:0] last_q, last_d;

  // index 0 is the most urgent class
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) sel = slot_i[i];
    end
  end

  assign any_act = |act_i;

  always_comb begin
    last_d = last_q;
    if (any_act) last_d = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end

  assign addr_o = any_act ? sel : last_q;

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_act && !$past(any_act) && !(|act_i)) |-> $stable(addr_o));
endmodule

// File: rtl/flash_err_addr_cap.sv
module flash_err_addr_cap
  import flash_eac_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int LANES  = 2,
  localparam int DW_W   = ADDR_W - DW_OFS,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int PAGE_W = DW_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  ded_lane_i,
  input  logic [PAGE_W-1:0] ded_page_i,
  input  logic              rww_evt_i,
  input  logic [DW_W-1:0]   rww_dw_i,
  input  logic              pe_fail_i,
  input  logic [DW_W-1:0]   pe_dw_i,
  input  logic [LANES-1:0]  sec_lane_i,
  input  logic [PAGE_W-1:0] sec_page_i,
  input  logic              sec_report_en_i,
  input  logic [NUM_CLS-1:0] flag_clr_i,
  output logic              ded_flag_o,
  output logic              rww_flag_o,
  output logic              pe_good_o,
  output logic              sec_flag_o,
  output logic [ADDR_W-1:0] err_addr_o
);
  logic [NUM_CLS-1:0]           hit;
  logic [NUM_CLS-1:0][DW_W-1:0] ev_dw;
  logic [NUM_CLS-1:0]           act;
  logic [NUM_CLS-1:0][DW_W-1:0] slot_dw;
  logic [DW_W-1:0]              rd_dw;
  logic                         sec_raw;

  eac_lane_merge #(.PAGE_W(PAGE_W), .LANES(LANES)) u_ded_merge (
    .lane_i (ded_lane_i),
    .page_i (ded_page_i),
    .hit_o  (hit[CLS_DED]),
    .dw_o   (ev_dw[CLS_DED])
  );

  eac_lane_merge #(.PAGE_W(PAGE_W), .LANES(LANES)) u_sec_merge (
    .lane_i (sec_lane_i),
    .page_i (sec_page_i),
    .hit_o  (sec_raw),
    .dw_o   (ev_dw[CLS_SEC])
  );

  assign hit[CLS_SEC]   = sec_raw && sec_report_en_i;
  assign hit[CLS_RWW]   = rww_evt_i;
  assign ev_dw[CLS_RWW] = rww_dw_i;
  assign hit[CLS_PEF]   = pe_fail_i;
  assign ev_dw[CLS_PEF] = pe_dw_i;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_slot
    eac_slot #(.W(DW_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (hit[g]),
      .addr_i (ev_dw[g]),
      .clr_i  (flag_clr_i[g]),
      .flag_o (act[g]),
      .addr_o (slot_dw[g])
    );
  end

  eac_read_sel #(.W(DW_W), .N(NUM_CLS)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_i  (act),
    .slot_i (slot_dw),
    .addr_o (rd_dw)
  );

  assign err_addr_o = {rd_dw, {DW_OFS{1'b0}}};
  assign ded_flag_o = act[CLS_DED];
  assign rww_flag_o = act[CLS_RWW];
  assign pe_good_o  = !act[CLS_PEF];
  assign sec_flag_o = act[CLS_SEC];

  p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_addr_o[DW_OFS-1:0] == '0);
  p_ded_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ded_flag_o |-> (err_addr_o[ADDR_W-1:DW_OFS] == slot_dw[CLS_DED]));
  p_sec_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_report_en_i && !sec_flag_o && !flag_clr_i[CLS_SEC]) |=> !sec_flag_o);
  p_pe_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pe_fail_i |=> !pe_good_o);
endmodule

// File: tb/flash_err_addr_cap_tb.sv
module flash_err_addr_cap_tb;
  localparam int ADDR_W = 23;
  localparam int LANES  = 2;
  localparam int DW_W   = 20;
  localparam int PAGE_W = 19;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [3:0]        flags; // {ded, rww, pe_good, sec}
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [LANES-1:0]  ded_lane, sec_lane;
  logic [PAGE_W-1:0] ded_page, sec_page;
  logic              rww_evt, pe_fail, sec_en;
  logic [DW_W-1:0]   rww_dw, pe_dw;
  logic [3:0]        clr;
  logic              ded_flag, rww_flag, pe_good, sec_flag;
  logic [ADDR_W-1:0] err_addr;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #5 clk = ~clk;

  flash_err_addr_cap #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .ded_lane_i (ded_lane), .ded_page_i (ded_page),
    .rww_evt_i (rww_evt), .rww_dw_i (rww_dw),
    .pe_fail_i (pe_fail), .pe_dw_i (pe_dw),
    .sec_lane_i (sec_lane), .sec_page_i (sec_page),
    .sec_report_en_i (sec_en), .flag_clr_i (clr),
    .ded_flag_o (ded_flag), .rww_flag_o (rww_flag),
    .pe_good_o (pe_good), .sec_flag_o (sec_flag),
    .err_addr_o (err_addr)
  );

  // monitor: compare one expectation per cycle, shortly after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [3:0] f;
      e = q.pop_front();
      f = {ded_flag, rww_flag, pe_good, sec_flag};
      n_cmp++;
      if (err_addr !== e.addr) begin
        n_bad++;
        $display("FAIL %s address: actual %h expected %h", e.tag, err_addr, e.addr);
      end
      n_cmp++;
      if (f !== e.flags) begin
        n_bad++;
        $display("FAIL %s flags: actual %b expected %b", e.tag, f, e.flags);
      end
    end
  end

  task automatic drive_idle();
    ded_lane = '0; ded_page = '0; sec_lane = '0; sec_page = '0;
    rww_evt = 0; rww_dw = '0; pe_fail = 0; pe_dw = '0; sec_en = 1; clr = '0;
  endtask

  // one cycle of stimulus; expectation covers the state after the next edge
  task automatic step(input logic [1:0] dl, input logic [PAGE_W-1:0] dp,
                      input logic rw, input logic [DW_W-1:0] ra,
                      input logic pf, input logic [DW_W-1:0] pa,
                      input logic [1:0] sl, input logic [PAGE_W-1:0] sp,
                      input logic en, input logic [3:0] c,
                      input logic [DW_W-1:0] exp_dw, input logic [3:0] exp_f,
                      input string tag);
    exp_t e;
    @(negedge clk);
    ded_lane = dl; ded_page = dp; rww_evt = rw; rww_dw = ra;
    pe_fail = pf; pe_dw = pa; sec_lane = sl; sec_page = sp;
    sec_en = en; clr = c;
    e.addr = {exp_dw, 3'b000};
    e.flags = exp_f;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    drive_idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    step(0,0, 0,0, 0,0, 0,0,     1, 4'b0000, 20'h0,     4'b0010, "R10 reset");
    // R9 correction recorded when enabled, lane 0
    step(0,0, 0,0, 0,0, 2'b01,19'h100, 1, 4'b0000, 20'h200, 4'b0011, "R9 sec capture");
    // R2 second correction ignored
    step(0,0, 0,0, 0,0, 2'b10,19'h101, 1, 4'b0000, 20'h200, 4'b0011, "R2 sec first kept");
    // R6 program/erase failure drops good, outranks correction
    step(0,0, 0,0, 1,20'h333, 0,0, 1, 4'b0000, 20'h333, 4'b0001, "R6 pe fail");
    // R1 read-while-write outranks program/erase
    step(0,0, 1,20'h444, 0,0, 0,0, 1, 4'b0000, 20'h444, 4'b0101, "R1 rww over pe");
    // R5 both lanes of page 0x0AB give bit3 0
    step(2'b11,19'h0AB, 0,0, 0,0, 0,0, 1, 4'b0000, 20'h156, 4'b1101, "R5 both lanes");
    // R2 later double error ignored
    step(2'b10,19'h0CD, 0,0, 0,0, 0,0, 1, 4'b0000, 20'h156, 4'b1101, "R2 ded first kept");
    // R3 third event, a correction, leaves the first double-error address
    step(0,0, 0,0, 0,0, 2'b01,19'h0EE, 1, 4'b0000, 20'h156, 4'b1101, "R3 three events");
    // R7 clearing double error exposes read-while-write slot
    step(0,0, 0,0, 0,0, 0,0, 1, 4'b0001, 20'h444, 4'b0101, "R7 clear ded");
    // R8 clear plus new event in the same cycle
    step(0,0, 1,20'h555, 0,0, 0,0, 1, 4'b0010, 20'h555, 4'b0101, "R8 clear and hit");
    // R6 R7 clear rww and pe: good back high, correction slot shown
    step(0,0, 0,0, 0,0, 0,0, 1, 4'b0110, 20'h200, 4'b0011, "R6 R7 clear rww pe");
    // R10 all clear, hold last selected address
    step(0,0, 0,0, 0,0, 0,0, 1, 4'b1000, 20'h200, 4'b0010, "R10 idle hold");
    // R9 correction while reporting disabled ignored
    step(0,0, 0,0, 0,0, 2'b10,19'h077, 0, 4'b0000, 20'h200, 4'b0010, "R9 sec disabled");
    // R5 simultaneous corrections
    step(0,0, 0,0, 0,0, 2'b11,19'h078, 1, 4'b0000, 20'h0F0, 4'b0011, "R5 sec both lanes");
    // R5 lane 1 alone sets bit3; R4 low bits zero
    step(2'b10,19'h010, 0,0, 0,0, 0,0, 1, 4'b0000, 20'h021, 4'b1011, "R5 R4 lane1");
    // R10 clear everything, last selected held
    step(0,0, 0,0, 0,0, 0,0, 1, 4'b1111, 20'h021, 4'b0010, "R10 clear all hold");
    step(0,0, 0,0, 0,0, 0,0, 1, 4'b0000, 20'h021, 4'b0010, "R10 idle");
    @(negedge clk);
    drive_idle();
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule